// File: doc/BRIEF.md
# Configurable-Frame Serial Transceiver

A full-duplex asynchronous serial transmitter and receiver whose frame layout is chosen by one packed configuration byte: seven or eight data bits, parity on or off, parity of the odd/even or the mark/space kind, and one or two stop bits. The host writes one byte at a time into a transmit holding register. Received bytes are queued in a 64-entry circular buffer whose head is always presented on `rxData` and is removed with a one-cycle `rxRead` pulse.

Bit timing comes from `baudTick`, an enable that pulses once per sixteenth of a bit. The transmitter holds each bit for sixteen ticks. The receiver synchronises the line, checks a falling edge again at mid-bit, and then samples each further bit at its centre. A status byte reports the transmit and receive activity, the fill state of the queue and three sticky error flags, which are cleared with `statusAck`.

Top module: `sxcvrTop`

## Requirements
- R1: Configuration bit 0 sets the data width: 1 gives eight data bits and 0 gives seven. In seven-bit mode only bits 6..0 of the transmit byte are sent, and bit 7 of every received byte reads as 0.
- R2: Configuration bit 7 = 1 adds a parity bit right after the data bits. With bit 6 = 1 the parity is odd (bit 5 = 1) or even (bit 5 = 0) over the data bits that are sent. With bit 6 = 0 the parity bit is a constant: 1 (mark) when bit 5 = 1 and 0 (space) when bit 5 = 0.
- R3: Configuration bit 1 = 1 sends two stop bits and bit 1 = 0 sends one. Stop bits are high.
- R4: `txLine` is high when idle. A frame is a low start bit followed by the data bits LSB first, then the parity bit if enabled, then the stop bits. Each bit lasts 16 `baudTick` pulses.
- R5: A `txWrite` pulse loads `txData` and sets status bit 7 (pending) from the next cycle until the frame starts. Status bit 6 is 1 while a frame is on the line.
- R6: The receiver accepts a start bit only if the line is still low 8 ticks after the falling edge. A shorter low pulse stores nothing. Status bit 1 is 1 while a frame is being received.
- R7: Each received byte is appended to a 64-entry FIFO. `rxData` shows the oldest byte, and `rxRead` removes it. Status bit 0 is 1 when the FIFO holds at least one byte. Status bit 5 is 1 when it holds two or more bytes.
- R8: If parity is enabled and the received parity bit differs from the configured rule, sticky status bit 4 is set. The byte is still stored.
- R9: If the first stop bit samples low, sticky status bit 3 is set. The byte is still stored.
- R10: If a byte completes while the FIFO holds 64 entries, sticky status bit 2 is set and the byte is dropped. The stored bytes are unchanged.
- R11: A `statusAck` pulse clears status bits 4..2 on the next cycle. It takes priority over a new error in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One pulse per 1/16 bit period |
| cfgByte | input | 8 | Frame configuration byte |
| txData | input | 8 | Byte to transmit |
| txWrite | input | 1 | Loads txData into the holding register |
| rxRead | input | 1 | Removes the head byte from the receive FIFO |
| statusAck | input | 1 | Clears the sticky error flags |
| rxLine | input | 1 | Serial receive line |
| txLine | output | 1 | Serial transmit line |
| rxData | output | 8 | Head byte of the receive FIFO |
| statusByte | output | 8 | {pending, sending, 2+ queued, parity err, framing err, overrun, receiving, ready} |

## Verification
The transmit waveform is sampled at the centre of every bit for eight frame formats. Together they cover both data widths, all four parity rules and both stop-bit counts, so a wrong parity polarity, a swapped bit order or a missing stop bit shows up as a wrong bit position. Each of those frames is also looped back into the receiver, which shows that both sides agree and that the top bit is cleared in seven-bit mode. Directed frames driven straight onto the receive line inject a wrong parity bit, a low stop bit and a glitch too short to be a start bit; each must raise only its own flag, or no byte at all. A run of 65 back-to-back frames fills the queue. It shows the overrun flag, the dropped last byte and the first-in-first-out order of the 64 stored bytes.

// File: rtl/sxcvr_pkg.sv
package sxcvr_pkg;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxStart;
    logic rxShift;
    logic rxFinish;
  } ctrlStrobes_t;

  // data bits plus optional parity bit
  function automatic logic [3:0] payloadBits(input logic [7:0] cfg);
    return (cfg[0] ? 4'd8 : 4'd7) + {3'd0, cfg[7]};
  endfunction

  // start + payload + stop bits
  function automatic logic [3:0] txFrameLen(input logic [7:0] cfg);
    return 4'd1 + payloadBits(cfg) + (cfg[1] ? 4'd2 : 4'd1);
  endfunction

  function automatic logic calcParity(input logic [7:0] cfg, input logic [7:0] data);
    if (cfg[6]) return cfg[5] ? ~^data : ^data;
    return cfg[5];
  endfunction

endpackage

// File: rtl/sxcvrCtrl.sv
module sxcvrCtrl
  import sxcvr_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         baudTick,
  input  logic [7:0]   cfgByte,
  input  logic         txPending,
  input  logic         rxIn,
  output ctrlStrobes_t strobes,
  output logic         txBusy,
  output logic         rxBusy
);
  localparam int TICK_W = $clog2(OVERSAMPLE);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(OVERSAMPLE - 1);
  localparam logic [TICK_W-1:0] HALF_TICK = TICK_W'(OVERSAMPLE / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxState_t;

  logic              txBusyQ;
  logic [TICK_W-1:0] txTickCnt;
  logic [3:0]        txBitsLeft;
  rxState_t          rxState;
  logic [TICK_W-1:0] rxTickCnt;
  logic [3:0]        rxBitsLeft;

  always_comb begin
    strobes.txLoad   = baudTick && !txBusyQ && txPending;
    strobes.txShift  = baudTick && txBusyQ && (txTickCnt == LAST_TICK);
    strobes.rxStart  = baudTick && (rxState == RX_START) && (rxTickCnt == HALF_TICK) && !rxIn;
    strobes.rxShift  = baudTick && (rxState == RX_BITS) && (rxTickCnt == LAST_TICK) && (rxBitsLeft != 4'd1);
    strobes.rxFinish = baudTick && (rxState == RX_BITS) && (rxTickCnt == LAST_TICK) && (rxBitsLeft == 4'd1);
  end

  assign txBusy = txBusyQ;
  assign rxBusy = (rxState != RX_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusyQ    <= 1'b0;
      txTickCnt  <= '0;
      txBitsLeft <= '0;
    end else if (baudTick) begin
      if (!txBusyQ) begin
        if (txPending) begin
          txBusyQ    <= 1'b1;
          txTickCnt  <= '0;
          txBitsLeft <= txFrameLen(cfgByte);
        end
      end else if (txTickCnt == LAST_TICK) begin
        txTickCnt  <= '0;
        txBitsLeft <= txBitsLeft - 4'd1;
        if (txBitsLeft == 4'd1) txBusyQ <= 1'b0;
      end else begin
        txTickCnt <= txTickCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState    <= RX_IDLE;
      rxTickCnt  <= '0;
      rxBitsLeft <= '0;
    end else if (baudTick) begin
      case (rxState)
        RX_IDLE: if (!rxIn) begin
          rxState   <= RX_START;
          rxTickCnt <= '0;
        end
        RX_START: if (rxTickCnt == HALF_TICK) begin
          rxTickCnt <= '0;
          if (!rxIn) begin
            rxState    <= RX_BITS;
            rxBitsLeft <= payloadBits(cfgByte) + 4'd1;
          end else begin
            rxState <= RX_IDLE;
          end
        end else begin
          rxTickCnt <= rxTickCnt + 1'b1;
        end
        RX_BITS: if (rxTickCnt == LAST_TICK) begin
          rxTickCnt  <= '0;
          rxBitsLeft <= rxBitsLeft - 4'd1;
          if (rxBitsLeft == 4'd1) rxState <= RX_IDLE;
        end else begin
          rxTickCnt <= rxTickCnt + 1'b1;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sxcvrDatapath.sv
module sxcvrDatapath
  import sxcvr_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int PTR_W = $clog2(FIFO_DEPTH),
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       cfgByte,
  input  logic [7:0]       txData,
  input  logic             txWrite,
  input  logic             rxRead,
  input  logic             statusAck,
  input  logic             rxIn,
  input  ctrlStrobes_t     strobes,
  input  logic             txBusy,
  input  logic             rxBusy,
  output logic             txLine,
  output logic             txPending,
  output logic [7:0]       rxData,
  output logic [7:0]       statusByte,
  output logic [CNT_W-1:0] fifoCount
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic [7:0]  holdReg;
  logic        pendingQ;
  logic [11:0] txSr;
  logic [11:0] txFrame;
  logic [7:0]  txBits;
  logic [3:0]  parPos;

  always_comb begin
    txBits = cfgByte[0] ? holdReg : {1'b0, holdReg[6:0]};
    parPos = cfgByte[0] ? 4'd9 : 4'd8;
    txFrame = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || cfgByte[0]) txFrame[i+1] = txBits[i];
    end
    if (cfgByte[7]) txFrame[parPos] = calcParity(cfgByte, txBits);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      pendingQ <= 1'b0;
      txSr     <= '1;
    end else begin
      if (strobes.txLoad) begin
        txSr     <= txFrame;
        pendingQ <= 1'b0;
      end else if (strobes.txShift) begin
        txSr <= {1'b1, txSr[11:1]};
      end
      if (txWrite) begin
        holdReg  <= txData;
        pendingQ <= 1'b1;
      end
    end
  end

  assign txLine    = txSr[0];
  assign txPending = pendingQ;

  // receive side
  logic [7:0] rxCfg;
  logic [8:0] rxSr;
  logic [8:0] rxAligned;
  logic [7:0] rxByte;
  logic       rxParBad;

  always_comb begin
    rxAligned = rxSr >> (4'd9 - payloadBits(rxCfg));
    rxByte    = rxCfg[0] ? rxAligned[7:0] : {1'b0, rxAligned[6:0]};
    rxParBad  = rxCfg[7] && (rxAligned[rxCfg[0] ? 8 : 7] != calcParity(rxCfg, rxByte));
  end

  logic [7:0]       fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] putIdx, getIdx;
  logic [CNT_W-1:0] countQ;
  logic             doPush, doPop;
  logic             parErrQ, frmErrQ, ovrErrQ;

  assign doPush = strobes.rxFinish && (countQ != FULL_CNT);
  assign doPop  = rxRead && (countQ != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCfg   <= '0;
      rxSr    <= '0;
      putIdx  <= '0;
      getIdx  <= '0;
      countQ  <= '0;
      parErrQ <= 1'b0;
      frmErrQ <= 1'b0;
      ovrErrQ <= 1'b0;
    end else begin
      if (strobes.rxStart) rxCfg <= cfgByte;
      if (strobes.rxShift) rxSr <= {rxIn, rxSr[8:1]};
      if (doPush) begin
        fifoMem[putIdx] <= rxByte;
        putIdx <= (putIdx == PTR_W'(FIFO_DEPTH - 1)) ? '0 : putIdx + 1'b1;
      end
      if (doPop) getIdx <= (getIdx == PTR_W'(FIFO_DEPTH - 1)) ? '0 : getIdx + 1'b1;
      countQ <= countQ + CNT_W'(doPush) - CNT_W'(doPop);
      if (statusAck) begin
        parErrQ <= 1'b0;
        frmErrQ <= 1'b0;
        ovrErrQ <= 1'b0;
      end else if (strobes.rxFinish) begin
        if (rxParBad) parErrQ <= 1'b1;
        if (!rxIn) frmErrQ <= 1'b1;
        if (countQ == FULL_CNT) ovrErrQ <= 1'b1;
      end
    end
  end

  assign rxData     = fifoMem[getIdx];
  assign fifoCount  = countQ;
  assign statusByte = {pendingQ, txBusy, (countQ > CNT_W'(1)), parErrQ,
                       frmErrQ, ovrErrQ, rxBusy, (countQ != '0)};
endmodule

// File: rtl/sxcvrTop.sv
module sxcvrTop
  import sxcvr_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int OVERSAMPLE = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic [7:0] cfgByte,
  input  logic [7:0] txData,
  input  logic       txWrite,
  input  logic       rxRead,
  input  logic       statusAck,
  input  logic       rxLine,
  output logic       txLine,
  output logic [7:0] rxData,
  output logic [7:0] statusByte
);
  logic [1:0]       rxMeta;
  logic             rxSync;
  ctrlStrobes_t     strobes;
  logic             txBusy, rxBusy, txPending;
  logic [CNT_W-1:0] fifoCount;

  always_ff @(posedge clk) begin
    if (!rstN) rxMeta <= 2'b11;
    else       rxMeta <= {rxMeta[0], rxLine};
  end
  assign rxSync = rxMeta[1];

  sxcvrCtrl #(.OVERSAMPLE(OVERSAMPLE)) i_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .cfgByte(cfgByte),
    .txPending(txPending), .rxIn(rxSync), .strobes(strobes),
    .txBusy(txBusy), .rxBusy(rxBusy)
  );

  sxcvrDatapath #(.FIFO_DEPTH(FIFO_DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .txData(txData),
    .txWrite(txWrite), .rxRead(rxRead), .statusAck(statusAck),
    .rxIn(rxSync), .strobes(strobes), .txBusy(txBusy), .rxBusy(rxBusy),
    .txLine(txLine), .txPending(txPending), .rxData(rxData),
    .statusByte(statusByte), .fifoCount(fifoCount)
  );
endmodule

// File: rtl/sxcvrChecker.sv
module sxcvrChecker #(
  parameter int FIFO_DEPTH = 64,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             txLine,
  input logic             txWrite,
  input logic             statusAck,
  input logic [7:0]       statusByte,
  input logic [CNT_W-1:0] fifoCount
);
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[6] |-> txLine);

  a_r4_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[6]) |-> !txLine);

  a_r5_pending_set: assert property (@(posedge clk) disable iff (!rstN)
    txWrite |=> statusByte[7]);

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(FIFO_DEPTH));

  a_r10_overrun_when_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[2]) |-> $past(fifoCount) == CNT_W'(FIFO_DEPTH));

  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    statusAck |=> statusByte[4:2] == 3'b000);
endmodule

bind sxcvrTop sxcvrChecker #(.FIFO_DEPTH(FIFO_DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .txLine(txLine), .txWrite(txWrite),
  .statusAck(statusAck), .statusByte(statusByte), .fifoCount(fifoCount)
);

// File: tb/test_sxcvrTop.sv
module test_sxcvrTop;
  logic       clk = 0;
  logic       rstN = 0;
  logic       baudTick = 0;
  logic [7:0] cfgByte = 8'h01;
  logic [7:0] txData = 0;
  logic       txWrite = 0, rxRead = 0, statusAck = 0;
  logic       loopSel = 1, rxDrive = 1;
  logic       rxLine, txLine;
  logic [7:0] rxData, statusByte;
  int checks = 0, failures = 0;
  bit done = 0;

  assign rxLine = loopSel ? txLine : rxDrive;

  sxcvrTop i_sxcvrTop (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .cfgByte(cfgByte),
    .txData(txData), .txWrite(txWrite), .rxRead(rxRead),
    .statusAck(statusAck), .rxLine(rxLine), .txLine(txLine),
    .rxData(rxData), .statusByte(statusByte)
  );

  always #2 clk = ~clk;                 // 250 MHz
  always @(negedge clk) baudTick <= ~baudTick;  // tick every 2 clocks, bit = 32 clocks

  // {cfg, data}
  localparam logic [15:0] VEC [8] = '{
    {8'h01, 8'hA5}, {8'hC0, 8'hF3}, {8'hE1, 8'h3C}, {8'hA3, 8'h81},
    {8'h81, 8'h7E}, {8'hE2, 8'h00}, {8'hC3, 8'hFF}, {8'h02, 8'h80}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expParity(input logic [7:0] cfg, input logic [7:0] d);
    int ones = $countones(d);
    if (cfg[6]) return cfg[5] ? ((ones % 2) == 0) : ((ones % 2) == 1);
    return cfg[5];
  endfunction

  // builds the expected serial bit sequence from the requirements
  task automatic buildFrame(input logic [7:0] cfg, input logic [7:0] d,
                            output logic [11:0] bits, output int len);
    int nd = cfg[0] ? 8 : 7;
    logic [7:0] dm = cfg[0] ? d : {1'b0, d[6:0]};
    len = 0; bits = '1;
    bits[len++] = 1'b0;
    for (int i = 0; i < nd; i++) bits[len++] = dm[i];
    if (cfg[7]) bits[len++] = expParity(cfg, dm);
    bits[len++] = 1'b1;
    if (cfg[1]) bits[len++] = 1'b1;
  endtask

  task automatic popByte;
    @(negedge clk) rxRead = 1;
    @(negedge clk) rxRead = 0;
  endtask

  task automatic ackStatus;
    @(negedge clk) statusAck = 1;
    @(negedge clk) statusAck = 0;
  endtask

  task automatic driveRx(input logic [11:0] bits, input int len, input bit probe);
    loopSel = 0;
    for (int i = 0; i < len; i++) begin
      rxDrive = bits[i];
      repeat (32) @(negedge clk);
      if (probe && i == 2) chk(statusByte[1] == 1'b1, "R6 receiving flag", statusByte[1], 1);
    end
    rxDrive = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic txCase(input logic [7:0] cfg, input logic [7:0] d);
    logic [11:0] bits; int len;
    logic [7:0] expRx = cfg[0] ? d : {1'b0, d[6:0]};
    buildFrame(cfg, d, bits, len);
    loopSel = 1; cfgByte = cfg; txData = d;
    @(negedge clk) txWrite = 1;
    @(negedge clk) txWrite = 0;
    chk(statusByte[7] == 1'b1, "R5 pending after write", statusByte[7], 1);
    while (txLine) @(negedge clk);
    chk(statusByte[6] == 1'b1, "R5 sending flag", statusByte[6], 1);
    repeat (16) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      chk(txLine == bits[i], $sformatf("R4 R1 R2 R3 tx bit %0d cfg=%0h", i, cfg), txLine, bits[i]);
      repeat (32) @(negedge clk);
    end
    chk(statusByte[6] == 1'b0 && txLine, "R4 idle after frame", statusByte[6], 0);
    chk(rxData == expRx, $sformatf("R1 R7 loopback cfg=%0h", cfg), rxData, expRx);
    chk(statusByte[4:2] == 3'b000 && statusByte[0], "R8 no error on good frame", statusByte, 1);
    popByte();
    chk(statusByte[0] == 1'b0, "R7 empty after read", statusByte[0], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [11:0] fb; int fl;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(statusByte == 8'h00, "R5 R7 reset status", statusByte, 0);
    chk(txLine == 1'b1, "R4 reset idle line", txLine, 1);

    foreach (VEC[k]) txCase(VEC[k][15:8], VEC[k][7:0]);

    // R8: even parity, data 01 needs parity 1; send 0
    cfgByte = 8'hC1;
    fb = '1; fb[0] = 0; fb[8:1] = 8'h01; fb[9] = 0;
    driveRx(fb, 11, 0);
    chk(statusByte[4] == 1'b1, "R8 parity error flag", statusByte[4], 1);
    chk(statusByte[3:2] == 2'b00, "R8 only parity flag", statusByte[3:2], 0);
    chk(rxData == 8'h01, "R8 byte kept", rxData, 8'h01);
    ackStatus();
    chk(statusByte[4:2] == 3'b000, "R11 ack clears flags", statusByte[4:2], 0);
    popByte();

    // R9: low stop bit
    cfgByte = 8'h01;
    fb = '1; fb[0] = 0; fb[8:1] = 8'h5A; fb[9] = 0;
    driveRx(fb, 10, 0);
    chk(statusByte[3] == 1'b1, "R9 framing error flag", statusByte[3], 1);
    chk(rxData == 8'h5A, "R9 byte kept", rxData, 8'h5A);
    ackStatus();
    popByte();

    // R6: glitch of 3 ticks
    loopSel = 0;
    @(negedge clk) rxDrive = 0;
    repeat (6) @(negedge clk);
    rxDrive = 1;
    repeat (64) @(negedge clk);
    chk(statusByte[1] == 1'b0, "R6 glitch not receiving", statusByte[1], 0);
    chk(statusByte[0] == 1'b0, "R6 glitch stores nothing", statusByte[0], 0);

    // R7/R10: fill the queue and overflow it
    cfgByte = 8'h01;
    for (int n = 0; n < 65; n++) begin
      buildFrame(8'h01, 8'(n), fb, fl);
      driveRx(fb, fl, n == 0);
      if (n == 0) chk(statusByte[5] == 1'b0, "R7 one byte no multi flag", statusByte[5], 0);
      if (n == 1) chk(statusByte[5] == 1'b1, "R7 two bytes multi flag", statusByte[5], 1);
      if (n == 63) chk(statusByte[2] == 1'b0, "R10 no overrun at 64", statusByte[2], 0);
    end
    chk(statusByte[2] == 1'b1, "R10 overrun flag", statusByte[2], 1);
    for (int n = 0; n < 64; n++) begin
      chk(rxData == 8'(n), "R10 R7 fifo order", rxData, n);
      popByte();
    end
    chk(statusByte[0] == 1'b0, "R10 extra byte dropped", statusByte[0], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule